// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit I/O virtual address into a physical address by reading two table entries from memory. The upper ten address bits pick an entry in a directory page whose location comes from a base input; that entry, when marked valid, gives the page holding the second-level table. The next ten bits pick an entry there, and that entry gives the physical page, its access rights and its cache attributes. The low twelve bits pass straight through as the byte offset.

A client offers a request (virtual address plus a write flag) while the walker is idle. The walker then issues at most two word reads on a simple request/response memory port and ends with a one-cycle result. The result is a translation, a page fault or a bus error, and it always carries the virtual address and the access direction. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_req_valid` and `res_valid` are 0.
- R2: The first read goes to `{dir_base[31:12], vaddr[31:22], 2'b00}`; bits 11:0 of `dir_base` have no effect, and `dir_base` is sampled when the request is accepted.
- R3: When the directory entry has bit 0 set, the second read goes to `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: A walk that succeeds gives `res_kind` = 0 and `res_paddr` = `{page_entry[31:12], vaddr[11:0]}`.
- R5: A directory entry with bit 0 clear gives `res_kind` = 1 (page fault), and no second read is issued.
- R6: A page entry with bit 0 clear gives `res_kind` = 1.
- R7: The page entry carries a readable flag in bit 1 and a writable flag in bit 2. A write to a valid entry with bit 2 clear, or a read from one with bit 1 clear, gives `res_kind` = 1.
- R8: A read answered with `mem_rsp_err` gives `res_kind` = 2 (bus error), whatever the returned data. After such an error no further read is issued.
- R9: On success `res_cache_ovr` equals page-entry bit 3. `res_cache` equals page-entry bits 8:4 (read allocate, read cache, write buffer, write allocate, write cache, from bit 8 down) when bit 3 is set, and is 0 when bit 3 is clear.
- R10: From acceptance to the end of the result cycle `req_ready` is 0 and requests offered in that time are ignored. At most one memory read is outstanding.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R12: `res_valid` is a one-cycle pulse in the cycle after the deciding response, followed by `req_ready` = 1. `res_vaddr` and `res_write` echo the request. On a fault or bus error `res_paddr`, `res_cache` and `res_cache_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle; request accepted when both are high |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| dir_base | input | 32 | Directory page address (bits 31:12 used) |
| mem_req_valid | output | 1 | Table word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read |
| mem_rsp_err | input | 1 | Read ended in a bus error |
| res_valid | output | 1 | Result pulse |
| res_kind | output | 2 | 0 translated, 1 page fault, 2 bus error |
| res_paddr | output | 32 | Physical address on success |
| res_cache_ovr | output | 1 | Cache attribute override flag |
| res_cache | output | 5 | Cache attribute bits when overridden |
| res_vaddr | output | 32 | Virtual address of the walk |
| res_write | output | 1 | Direction of the walk |

## Verification
A wrong index slice or base field shows up at once on `mem_req_addr`, in the cycle the read is raised, before any data returns. A wrong decision on valid, permission or error bits shows up as a wrong `res_kind` in the result pulse one cycle after the deciding response. A state machine that issues an extra read or releases `req_ready` too early shows up as a request, or an accepted poke, within a cycle of the result. The sweep checks each of these at its exact cycle over a hashed memory image with varied latencies.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int IDX_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [2*IDX_W+IDX_W+1:0]    req_vaddr,
  input  logic                        req_write,
  input  logic [2*IDX_W+IDX_W+1:0]    dir_base,
  output logic                        mem_req_valid,
  input  logic                        mem_req_ready,
  output logic [2*IDX_W+IDX_W+1:0]    mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [2*IDX_W+IDX_W+1:0]    mem_rsp_data,
  input  logic                        mem_rsp_err,
  output logic                        res_valid,
  output logic [1:0]                  res_kind,
  output logic [2*IDX_W+IDX_W+1:0]    res_paddr,
  output logic                        res_cache_ovr,
  output logic [4:0]                  res_cache,
  output logic [2*IDX_W+IDX_W+1:0]    res_vaddr,
  output logic                        res_write
);
  localparam int OFF_W = IDX_W + 2;
  localparam int AW    = 2*IDX_W + OFF_W;
  localparam int PN_W  = AW - OFF_W;

  localparam logic [1:0] K_OK  = 2'd0;
  localparam logic [1:0] K_PF  = 2'd1;
  localparam logic [1:0] K_BUS = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_PREQ, S_PWAIT, S_DONE} st_t;

  st_t             st;
  logic [AW-1:0]   va;
  logic            wr;
  logic [PN_W-1:0] base_pn;
  logic [PN_W-1:0] pt_pn;
  logic [1:0]      kind_q;
  logic [AW-1:0]   paddr_q;
  logic            ovr_q;
  logic [4:0]      cache_q;

  logic entry_ok, perm_ok;
  logic unused_bits;

  assign entry_ok    = mem_rsp_data[0];
  assign perm_ok     = wr ? mem_rsp_data[2] : mem_rsp_data[1];
  assign unused_bits = ^{mem_rsp_data[OFF_W-1:9], dir_base[OFF_W-1:0]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DREQ) || (st == S_PREQ);
  assign mem_req_addr  = (st == S_DREQ) ? {base_pn, va[AW-1 -: IDX_W], 2'b00}
                                        : {pt_pn, va[OFF_W +: IDX_W], 2'b00};
  assign res_valid     = (st == S_DONE);
  assign res_kind      = kind_q;
  assign res_paddr     = paddr_q;
  assign res_cache_ovr = ovr_q;
  assign res_cache     = cache_q;
  assign res_vaddr     = va;
  assign res_write     = wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va      <= '0;
      wr      <= 1'b0;
      base_pn <= '0;
      pt_pn   <= '0;
      kind_q  <= K_OK;
      paddr_q <= '0;
      ovr_q   <= 1'b0;
      cache_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va      <= req_vaddr;
          wr      <= req_write;
          base_pn <= dir_base[AW-1:OFF_W];
          kind_q  <= K_OK;
          paddr_q <= '0;
          ovr_q   <= 1'b0;
          cache_q <= '0;
          st      <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            kind_q <= K_BUS;
            st     <= S_DONE;
          end else if (!entry_ok) begin
            kind_q <= K_PF;
            st     <= S_DONE;
          end else begin
            pt_pn <= mem_rsp_data[AW-1:OFF_W];
            st    <= S_PREQ;
          end
        end
        S_PREQ: if (mem_req_ready) st <= S_PWAIT;
        S_PWAIT: if (mem_rsp_valid) begin
          st <= S_DONE;
          if (mem_rsp_err)               kind_q <= K_BUS;
          else if (!entry_ok || !perm_ok) kind_q <= K_PF;
          else begin
            kind_q  <= K_OK;
            paddr_q <= {mem_rsp_data[AW-1:OFF_W], va[OFF_W-1:0]};
            ovr_q   <= mem_rsp_data[3];
            cache_q <= mem_rsp_data[3] ? mem_rsp_data[8:4] : 5'd0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int IDX_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_ready,
  input logic                     mem_req_valid,
  input logic                     mem_req_ready,
  input logic [2*IDX_W+IDX_W+1:0] mem_req_addr,
  input logic                     res_valid,
  input logic [1:0]               res_kind,
  input logic [2*IDX_W+IDX_W+1:0] res_paddr,
  input logic                     res_cache_ovr,
  input logic [4:0]               res_cache,
  input logic [2*IDX_W+IDX_W+1:0] res_vaddr
);
  localparam int OFF_W = IDX_W + 2;

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R10
  AST_VADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(res_vaddr)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && req_ready); // R12
  AST_RES_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid); // R8
  AST_OK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 2'd0 |-> res_paddr[OFF_W-1:0] == res_vaddr[OFF_W-1:0]); // R4
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_kind != 2'd3); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind != 2'd0 |-> res_paddr == '0 && res_cache == '0 && !res_cache_ovr); // R12
  AST_NO_OVR_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_cache_ovr |-> res_cache == '0); // R9
endmodule

bind ptw_walker ptw_walker_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_ready;
  logic [31:0] req_vaddr, dir_base;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        res_valid, res_cache_ovr, res_write;
  logic [1:0]  res_kind;
  logic [31:0] res_paddr, res_vaddr;
  logic [4:0]  res_cache;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ptw_walker u_ptw_walker (.*);

  function automatic logic [31:0] memw(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // serve one read that the walker should be raising at this negedge
  task automatic serve(input logic [31:0] exp_addr, input string tag, input bit err, input int lat);
    logic [31:0] a;
    chk({tag, " read raised"}, {31'd0, mem_req_valid}, 32'd1);
    chk({tag, " read address"}, mem_req_addr, exp_addr);
    a = mem_req_addr;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk("R11 request held", {31'd0, mem_req_valid}, 32'd1);
      chk("R11 address stable", mem_req_addr, a);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R10 single outstanding read", {31'd0, mem_req_valid}, 32'd0);
    for (int k = 0; k < lat; k++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_err   = err;
    mem_rsp_data  = memw(a);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_err   = 1'b0;
    mem_rsp_data  = 32'h0;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                      input int errsel, input int lat, input bit poke);
    logic [31:0] dva, dte, pva, pte, exp_pa;
    logic [1:0]  ek;
    logic        second, ovr;
    logic [4:0]  cache;
    dva = {base[31:12], va[31:22], 2'b00};
    dte = memw(dva);
    pva = {dte[31:12], va[21:12], 2'b00};
    pte = memw(pva);
    second = (errsel != 1) && dte[0];
    exp_pa = 32'h0; ovr = 1'b0; cache = 5'h0;
    if (errsel == 1)                   ek = 2'd2;
    else if (!dte[0])                  ek = 2'd1;
    else if (errsel == 2)              ek = 2'd2;
    else if (!pte[0])                  ek = 2'd1;
    else if (wr ? !pte[2] : !pte[1])   ek = 2'd1;
    else begin
      ek = 2'd0;
      exp_pa = {pte[31:12], va[11:0]};
      ovr = pte[3];
      cache = pte[3] ? pte[8:4] : 5'h0;
    end

    chk("R12 idle before walk", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; dir_base = base;
    @(negedge clk);
    req_valid = poke; req_vaddr = ~va; req_write = ~wr; dir_base = ~base;
    chk("R10 busy after accept", {31'd0, req_ready}, 32'd0);
    serve(dva, "R2", errsel == 1, lat);
    if (second) serve(pva, "R3", errsel == 2, (lat + 1) % 3);
    chk("R12 result pulse", {31'd0, res_valid}, 32'd1);
    chk("R5 R8 no read after decision", {31'd0, mem_req_valid}, 32'd0);
    chk("R4 R5 R6 R7 R8 result kind", {30'd0, res_kind}, {30'd0, ek});
    chk("R4 physical address", res_paddr, exp_pa);
    chk("R9 override flag", {31'd0, res_cache_ovr}, {31'd0, ovr});
    chk("R9 cache attributes", {27'd0, res_cache}, {27'd0, cache});
    chk("R12 vaddr echo", res_vaddr, va);
    chk("R7 direction echo", {31'd0, res_write}, {31'd0, wr});
    req_valid = 1'b0;
    @(negedge clk);
    chk("R12 pulse ends", {31'd0, res_valid}, 32'd0);
    chk("R10 busy poke ignored", {31'd0, mem_req_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_vaddr = 32'h0; dir_base = 32'h0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset no read", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 reset no result", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 1600; i++) begin
      logic [31:0] va, base;
      int errsel;
      va     = memw(i + 32'h5000) ^ (i << 22);
      base   = memw(i + 32'h77);
      errsel = (i % 11 == 5) ? 1 : ((i % 13 == 7) ? 2 : 0);
      walk(va, i[0], base, errsel, i % 3, (i % 4) == 3);
    end
    summary();
  end
endmodule